// File: doc/BRIEF.md
# Multi-width asynchronous SRAM controller

This block sits between a synchronous host request port and an array of four byte-wide asynchronous SRAM banks. The banks share the address bus and a single output-enable. Each bank has its own active-low chip-select and write-enable. A static layout input chooses how the four banks are used. They can form one 32-bit memory, two 16-bit memories, or four independent 8-bit memories. The controller remaps chip-selects, write-enables, address bits and data lanes to match the chosen layout.

Every transfer is a fixed run of whole clock cycles. A write has three phases: a setup phase with the bank selected and write-enable high, a write pulse, and a hold phase with the data still driven. A read keeps chip-select and output-enable low for a fixed number of cycles and captures the data on the last of them. The phase lengths are parameters. The integrator sets each one to at least its nanosecond limit divided by the clock period, rounded up. The defaults are chosen for a 5 ns clock.

While a transfer runs, the controller raises `busy`. It pulses `done` for one cycle when the transfer finishes.

Top module: `sram_width_ctrl`

## Requirements
- R1: While reset is held, and whenever `busy` is low, all chip-selects and write-enables are high, output-enable is high, the data drivers are off, and `busy` and `done` are low.
- R2: In layout 0 (32-bit), all four chip-selects go low together. Write-enable `i` goes low only if byte strobe `i` is set, and host byte `i` is driven on lane `i`. The memory address is host address bits [20:2].
- R3: In layout 1 (16-bit), host address bit 20 picks the bank. A 0 selects chip-selects 0 and 1; a 1 selects chip-selects 2 and 3. Within the selected bank, strobe 0 enables the low byte and strobe 1 the high byte. Host data [15:0] is driven on both lane pairs. The memory address is host address bits [19:1]. A read returns the bank's 16 bits on read data [15:0], with the upper bits zero.
- R4: In layout 2 (8-bit), host address bits [20:19] pick one chip-select. All four write-enables pulse together whatever the byte strobes are. Host data [7:0] is driven on every lane. The memory address is host address bits [18:0]. A read returns the selected lane on read data [7:0], with the upper bits zero.
- R5: A write holds the bank selected with write-enable high for SETUP_CYC cycles. It then holds write-enable low for exactly PULSE_CYC cycles, and keeps the data driven for HOLD_CYC cycles after write-enable rises. The data drivers are off during setup, and output-enable stays high throughout.
- R6: A read holds chip-select and output-enable low for exactly READ_CYC cycles, with all write-enables high and the data drivers off. Data is captured on the last of those cycles.
- R7: `done` is high for exactly one cycle, the first cycle after the transfer with `busy` low. Read data holds its value until the next read completes, so a write does not change it.
- R8: A request made while `busy` is high is not taken and does not disturb the running transfer. A request present in the cycle where `done` is high is accepted.
- R9: Layout 3 is reserved. A transfer in this layout asserts no chip-select and no write-enable, leaves memory contents unchanged, still ends with `done`, and a read returns zero.
- R10: In layout 1, the chip-selects and write-enables of the bank not addressed stay high for the whole transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | Bank layout: 0 = 32-bit, 1 = 16-bit, 2 = 8-bit, 3 = reserved |
| req_valid | input | 1 | Transfer request, taken when `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Host byte address |
| req_wdata | input | 32 | Host write data |
| req_be | input | 4 | Byte strobes |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read result, aligned to the layout |
| mem_addr | output | 19 | Memory address bus |
| mem_cs_n | output | 4 | Per-bank chip-select, active low |
| mem_we_n | output | 4 | Per-bank write-enable, active low |
| mem_oe_n | output | 1 | Shared output-enable, active low |
| mem_dq_oe | output | 1 | Data driver enable toward the memory |
| mem_dq_out | output | 32 | Data lanes driven toward the memory |
| mem_dq_in | input | 32 | Data lanes returned from the memory |

## Verification
The completion pulse of one transfer and the acceptance of the next request can fall in the same cycle. The bench provokes this by raising a read request during a write and holding it through `busy`, with an address that differs from the write's. The bench then checks three things. First, the address stays that of the write for the whole write. Second, `busy` is low and `done` is high in the write's final cycle. Third, the following cycle already shows the read phase with output-enable low. Reading back both locations afterwards confirms that the write landed and the held request was served.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
// Shared types for the multi-width SRAM controller.
// Assumes four byte-wide banks; lane and bank counts are fixed here.
package sram_ctrl_pkg;
    localparam int NUM_BANKS = 4;
    localparam int LANE_W    = 8;
    localparam int DATA_W    = NUM_BANKS * LANE_W;

    typedef enum logic [1:0] {
        LAYOUT_W32  = 2'd0,
        LAYOUT_W16  = 2'd1,
        LAYOUT_W8   = 2'd2,
        LAYOUT_NONE = 2'd3
    } layout_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_PULSE = 3'd2,
        PH_HOLD  = 3'd3,
        PH_READ  = 3'd4
    } phase_e;
endpackage

// File: rtl/sram_lane_map.sv
`timescale 1ns/1ps
// Maps a host request onto the bank array for the selected layout:
// memory address, bank select mask, write-enable mask and lane data.
// Purely combinational; the caller registers the results when it accepts a request.
module sram_lane_map
    import sram_ctrl_pkg::*;
#(
    parameter int MADDR_W = 19,
    localparam int HADDR_W = MADDR_W + 2
) (
    input  layout_e               layout,
    input  logic [HADDR_W-1:0]    haddr,
    input  logic [DATA_W-1:0]     hwdata,
    input  logic [NUM_BANKS-1:0]  hbe,
    output logic [MADDR_W-1:0]    maddr,
    output logic [NUM_BANKS-1:0]  sel,
    output logic [NUM_BANKS-1:0]  wen,
    output logic [DATA_W-1:0]     lanes
);
    // Decode address, bank select, strobes and lane data per layout.
    always_comb begin
        maddr = '0;
        sel   = '0;
        wen   = '0;
        lanes = '0;
        case (layout)
            LAYOUT_W32: begin
                maddr = haddr[MADDR_W+1:2];
                sel   = '1;
                wen   = hbe;
                lanes = hwdata;
            end
            LAYOUT_W16: begin
                maddr = haddr[MADDR_W:1];
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (1'(b / 2) == haddr[HADDR_W-1]) begin
                        sel[b] = 1'b1;
                        wen[b] = hbe[b % 2];
                    end
                    lanes[b*LANE_W +: LANE_W] = hwdata[(b % 2)*LANE_W +: LANE_W];
                end
            end
            LAYOUT_W8: begin
                maddr = haddr[MADDR_W-1:0];
                wen   = '1;
                for (int b = 0; b < NUM_BANKS; b++) begin
                    sel[b] = (2'(b) == haddr[HADDR_W-1 -: 2]);
                    lanes[b*LANE_W +: LANE_W] = hwdata[LANE_W-1:0];
                end
            end
            default: begin
                maddr = '0;
            end
        endcase
    end
endmodule

// File: rtl/sram_phase_fsm.sv
`timescale 1ns/1ps
// Sequences one transfer through its timed phases.
// Writes: SETUP -> PULSE -> HOLD; reads: READ. Each phase lasts its parameter
// in clock cycles (each must be >= 1). Emits a one-cycle finish pulse.
module sram_phase_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 2,
    parameter int HOLD_CYC  = 1,
    parameter int READ_CYC  = 4,
    localparam int MAX_AB   = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC,
    localparam int MAX_CD   = (HOLD_CYC > READ_CYC) ? HOLD_CYC : READ_CYC,
    localparam int MAX_CYC  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD,
    localparam int CNT_W    = $clog2(MAX_CYC + 1)
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   start_write,
    output phase_e phase,
    output logic   last_cyc,
    output logic   finish
);
    logic [CNT_W-1:0] cnt_q;

    assign last_cyc = (cnt_q == '0);

    // Advance the phase when its cycle counter runs out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt_q  <= '0;
            finish <= 1'b0;
        end else begin
            finish <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= start_write ? PH_SETUP : PH_READ;
                        cnt_q <= start_write ? CNT_W'(SETUP_CYC - 1) : CNT_W'(READ_CYC - 1);
                    end
                end
                PH_SETUP: begin
                    if (last_cyc) begin
                        phase <= PH_PULSE;
                        cnt_q <= CNT_W'(PULSE_CYC - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_PULSE: begin
                    if (last_cyc) begin
                        phase <= PH_HOLD;
                        cnt_q <= CNT_W'(HOLD_CYC - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_HOLD, PH_READ: begin
                    if (last_cyc) begin
                        phase  <= PH_IDLE;
                        finish <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sram_read_align.sv
`timescale 1ns/1ps
// Moves the lanes of the selected bank down to the host's low bits.
// Assumes at most one 16-bit pair or one byte lane is selected in the narrow layouts.
module sram_read_align
    import sram_ctrl_pkg::*;
(
    input  layout_e               layout,
    input  logic [NUM_BANKS-1:0]  sel,
    input  logic [DATA_W-1:0]     lanes,
    output logic [DATA_W-1:0]     aligned
);
    localparam int HALF_W = DATA_W / 2;

    // Select and zero-extend the lanes that belong to the addressed bank.
    always_comb begin
        aligned = '0;
        case (layout)
            LAYOUT_W32: aligned = lanes;
            LAYOUT_W16: aligned[HALF_W-1:0] = sel[NUM_BANKS-1] ? lanes[DATA_W-1:HALF_W]
                                                               : lanes[HALF_W-1:0];
            LAYOUT_W8: begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (sel[b]) aligned[LANE_W-1:0] = lanes[b*LANE_W +: LANE_W];
                end
            end
            default: aligned = '0;
        endcase
    end
endmodule

// File: rtl/sram_width_ctrl.sv
`timescale 1ns/1ps
// Synchronous controller for four byte-wide asynchronous SRAM banks, arranged
// as one 32-bit, two 16-bit or four 8-bit memories by cfg_mode (static).
// Accepts a request when idle, latches its lane map, runs the timed phases and
// pulses done. Phase parameters must cover the memory limits at the clock period.
module sram_width_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int MADDR_W   = 19,
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 2,
    parameter int HOLD_CYC  = 1,
    parameter int READ_CYC  = 4,
    localparam int HADDR_W  = MADDR_W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           cfg_mode,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [HADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [NUM_BANKS-1:0] req_be,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_W-1:0]    rdata,
    output logic [MADDR_W-1:0]   mem_addr,
    output logic [NUM_BANKS-1:0] mem_cs_n,
    output logic [NUM_BANKS-1:0] mem_we_n,
    output logic                 mem_oe_n,
    output logic                 mem_dq_oe,
    output logic [DATA_W-1:0]    mem_dq_out,
    input  logic [DATA_W-1:0]    mem_dq_in
);
    layout_e               layout_in;
    layout_e               layout_q;
    logic [MADDR_W-1:0]    map_addr, addr_q;
    logic [NUM_BANKS-1:0]  map_sel, sel_q;
    logic [NUM_BANKS-1:0]  map_wen, wen_q;
    logic [DATA_W-1:0]     map_lanes, lanes_q;
    logic [DATA_W-1:0]     rd_aligned, rdata_q;
    phase_e                phase;
    logic                  last_cyc, finish, accept;

    assign layout_in = layout_e'(cfg_mode);
    assign accept    = req_valid && (phase == PH_IDLE);

    sram_lane_map #(.MADDR_W(MADDR_W)) u_map (
        .layout (layout_in),
        .haddr  (req_addr),
        .hwdata (req_wdata),
        .hbe    (req_be),
        .maddr  (map_addr),
        .sel    (map_sel),
        .wen    (map_wen),
        .lanes  (map_lanes)
    );

    sram_phase_fsm #(
        .SETUP_CYC (SETUP_CYC),
        .PULSE_CYC (PULSE_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .READ_CYC  (READ_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .start_write (req_write),
        .phase       (phase),
        .last_cyc    (last_cyc),
        .finish      (finish)
    );

    sram_read_align u_align (
        .layout  (layout_q),
        .sel     (sel_q),
        .lanes   (mem_dq_in),
        .aligned (rd_aligned)
    );

    // Latch the mapped request so the memory pins stay stable for the transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            layout_q <= LAYOUT_NONE;
            addr_q   <= '0;
            sel_q    <= '0;
            wen_q    <= '0;
            lanes_q  <= '0;
        end else if (accept) begin
            layout_q <= layout_in;
            addr_q   <= map_addr;
            sel_q    <= map_sel;
            wen_q    <= req_write ? map_wen : '0;
            lanes_q  <= map_lanes;
        end
    end

    // Capture read data on the final read cycle; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (phase == PH_READ && last_cyc) begin
            rdata_q <= rd_aligned;
        end
    end

    // Drive the memory pins from the current phase and the latched map.
    always_comb begin
        mem_addr   = addr_q;
        mem_cs_n   = ~(sel_q & {NUM_BANKS{phase != PH_IDLE}});
        mem_we_n   = ~(wen_q & {NUM_BANKS{phase == PH_PULSE && (|sel_q)}});
        mem_oe_n   = (phase != PH_READ);
        mem_dq_oe  = (phase == PH_PULSE || phase == PH_HOLD) && (|sel_q);
        mem_dq_out = lanes_q;
    end

    assign busy  = (phase != PH_IDLE);
    assign done  = finish;
    assign rdata = rdata_q;
endmodule

// File: rtl/sram_width_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for sram_width_ctrl, bound to every instance.
// Assumes cfg_mode is static while the controller is in use.
module sram_width_ctrl_chk #(
    parameter int MADDR_W   = 19,
    parameter int PULSE_CYC = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         cfg_mode,
    input logic               busy,
    input logic               done,
    input logic [MADDR_W-1:0] mem_addr,
    input logic [3:0]         mem_cs_n,
    input logic [3:0]         mem_we_n,
    input logic               mem_oe_n,
    input logic               mem_dq_oe
);
    logic       we_low, we_low_q;
    logic [7:0] we_run_q;

    assign we_low = !(&mem_we_n);

    // Count consecutive cycles with any write-enable low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_run_q <= '0;
            we_low_q <= 1'b0;
        end else begin
            we_low_q <= we_low;
            we_run_q <= we_low ? we_run_q + 8'd1 : 8'd0;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&mem_cs_n && &mem_we_n && mem_oe_n && !mem_dq_oe));

    assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    assert_pulse_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we_low_q && !we_low) |-> (we_run_q == 8'(PULSE_CYC)));

    assert_data_at_we_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(&mem_we_n) |-> mem_dq_oe);

    assert_data_after_we_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(&mem_we_n) |-> mem_dq_oe);

    assert_read_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (&mem_we_n && !mem_dq_oe));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_addr));

    assert_pair_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd1) |-> (mem_cs_n[0] == mem_cs_n[1] && mem_cs_n[2] == mem_cs_n[3]));

    assert_reserved_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd3) |-> (&mem_cs_n && &mem_we_n));
endmodule

bind sram_width_ctrl sram_width_ctrl_chk #(
    .MADDR_W   (MADDR_W),
    .PULSE_CYC (PULSE_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_mode  (cfg_mode),
    .busy      (busy),
    .done      (done),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_width_ctrl_bench.sv
`timescale 1ns/1ps
module sram_width_ctrl_bench;
    localparam int SETUP_C = 1;
    localparam int PULSE_C = 2;
    localparam int HOLD_C  = 1;
    localparam int READ_C  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [20:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        busy, done, mem_oe_n, mem_dq_oe;
    logic [31:0] rdata, mem_dq_out, mem_dq_in;
    logic [18:0] mem_addr;
    logic [3:0]  mem_cs_n, mem_we_n;

    int n_chk = 0;
    int n_pass = 0;
    int cyc = 0;
    bit finished = 0;

    logic [7:0] sram_arr [4][16];
    logic [7:0] shadow   [4][16];

    always #2.5 clk = ~clk;

    sram_width_ctrl #(
        .SETUP_CYC (SETUP_C),
        .PULSE_CYC (PULSE_C),
        .HOLD_CYC  (HOLD_C),
        .READ_CYC  (READ_C)
    ) u_sram_width_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .busy(busy), .done(done), .rdata(rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe), .mem_dq_out(mem_dq_out),
        .mem_dq_in(mem_dq_in)
    );

    // Simple level-sensitive SRAM model of the four banks (16 words each).
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 4; b++)
                for (int w = 0; w < 16; w++) sram_arr[b][w] <= 8'h00;
        end else begin
            for (int b = 0; b < 4; b++)
                if (!mem_cs_n[b] && !mem_we_n[b] && mem_dq_oe)
                    sram_arr[b][mem_addr[3:0]] <= mem_dq_out[b*8 +: 8];
        end
    end

    always_comb begin
        for (int b = 0; b < 4; b++)
            mem_dq_in[b*8 +: 8] = (!mem_cs_n[b] && !mem_oe_n) ? sram_arr[b][mem_addr[3:0]] : 8'hEE;
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (ok) n_pass++;
        else $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    endtask

    function automatic logic [18:0] e_maddr(input logic [1:0] m, input logic [20:0] a);
        case (m)
            2'd0:    return a[20:2];
            2'd1:    return a[19:1];
            default: return a[18:0];
        endcase
    endfunction

    function automatic logic [3:0] e_sel(input logic [1:0] m, input logic [20:0] a);
        case (m)
            2'd0:    return 4'hF;
            2'd1:    return a[20] ? 4'b1100 : 4'b0011;
            2'd2:    return 4'b0001 << a[20:19];
            default: return 4'h0;
        endcase
    endfunction

    function automatic logic [3:0] e_wen(input logic [1:0] m, input logic [20:0] a, input logic [3:0] be);
        case (m)
            2'd0:    return be;
            2'd1:    return a[20] ? {be[1:0], 2'b00} : {2'b00, be[1:0]};
            2'd2:    return 4'hF;
            default: return 4'h0;
        endcase
    endfunction

    function automatic logic [31:0] e_lanes(input logic [1:0] m, input logic [31:0] d);
        case (m)
            2'd0:    return d;
            2'd1:    return {2{d[15:0]}};
            default: return {4{d[7:0]}};
        endcase
    endfunction

    function automatic logic [31:0] e_rdata(input logic [1:0] m, input logic [20:0] a);
        logic [3:0] ix;
        ix = e_maddr(m, a)[3:0];
        case (m)
            2'd0: return {shadow[3][ix], shadow[2][ix], shadow[1][ix], shadow[0][ix]};
            2'd1: return a[20] ? {16'h0, shadow[3][ix], shadow[2][ix]}
                               : {16'h0, shadow[1][ix], shadow[0][ix]};
            2'd2: return {24'h0, shadow[a[20:19]][ix]};
            default: return 32'h0;
        endcase
    endfunction

    // Generic transfer with pin-level checks against the requirements.
    task automatic run_xfer(input logic [1:0] m, input bit wr, input logic [20:0] a,
                            input logic [31:0] d, input logic [3:0] be, input string rq);
        logic [3:0]  xs, xw, wseen;
        logic [31:0] xl, dseen;
        logic [18:0] xa;
        int ns, np, nh, nr, guard;
        bit bad_cs, bad_addr, bad_oe, bad_dq, bad_we, saw;
        xs = e_sel(m, a); xw = e_wen(m, a, be); xl = e_lanes(m, d); xa = e_maddr(m, a);
        ns = 0; np = 0; nh = 0; nr = 0; guard = 0;
        bad_cs = 0; bad_addr = 0; bad_oe = 0; bad_dq = 0; bad_we = 0; saw = 0;
        wseen = '0; dseen = '0;
        @(negedge clk);
        while (busy) @(negedge clk);
        cfg_mode = m; req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && guard < 64) begin
            guard++;
            if ((~mem_cs_n) != xs) bad_cs = 1;
            if (m != 2'd3 && mem_addr != xa) bad_addr = 1;
            if (wr) begin
                if (!mem_oe_n) bad_oe = 1;
                if (m == 2'd3) begin
                    if (!(&mem_we_n)) bad_we = 1;
                end else if (&mem_we_n) begin
                    if (saw) begin nh++; if (!mem_dq_oe) bad_dq = 1; end
                    else begin ns++; if (mem_dq_oe) bad_dq = 1; end
                end else begin
                    saw = 1; np++; wseen = ~mem_we_n; dseen = mem_dq_out;
                    if (!mem_dq_oe) bad_dq = 1;
                end
            end else begin
                if (!mem_oe_n) nr++;
                if (mem_dq_oe) bad_dq = 1;
                if (!(&mem_we_n)) bad_we = 1;
            end
            @(negedge clk);
        end
        chk(done == 1'b1, "R7", "done at end", {31'h0, done}, 32'h1);
        chk(busy == 1'b0, "R7", "busy low with done", {31'h0, busy}, 32'h0);
        chk(!bad_cs, rq, "chip-select pattern", {28'h0, xs}, {28'h0, xs});
        chk(!bad_addr, rq, "memory address", {13'h0, mem_addr}, {13'h0, xa});
        if (wr && m != 2'd3) begin
            chk(ns == SETUP_C, "R5", "setup cycles", ns, SETUP_C);
            chk(np == PULSE_C, "R5", "pulse cycles", np, PULSE_C);
            chk(nh == HOLD_C, "R5", "hold cycles", nh, HOLD_C);
            chk(!bad_dq && !bad_oe, "R5", "driver/oe window", {30'h0, bad_dq, bad_oe}, 32'h0);
            chk(wseen == xw, rq, "write-enable mask", {28'h0, wseen}, {28'h0, xw});
            chk(dseen == xl, rq, "lane data", dseen, xl);
            for (int b = 0; b < 4; b++)
                if (xs[b] && xw[b]) shadow[b][xa[3:0]] = xl[b*8 +: 8];
        end else if (wr) begin
            chk(!bad_we, "R9", "reserved write-enables high", {31'h0, bad_we}, 32'h0);
        end else begin
            chk(nr == READ_C, "R6", "read cycles", nr, READ_C);
            chk(!bad_dq && !bad_we, "R6", "read bus quiet", {30'h0, bad_dq, bad_we}, 32'h0);
            chk(rdata == e_rdata(m, a), rq, "read data", rdata, e_rdata(m, a));
        end
        @(negedge clk);
        chk(done == 1'b0, "R7", "done single cycle", {31'h0, done}, 32'h0);
    endtask

    task automatic t_reset;
        chk(&mem_cs_n && &mem_we_n && mem_oe_n && !mem_dq_oe && !busy && !done, "R1",
            "reset pins", {22'h0, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe},
            {22'h0, 4'hF, 4'hF, 1'b1, 1'b0});
    endtask

    task automatic t_word32;
        run_xfer(2'd0, 1'b1, 21'h000010, 32'hA1B2C3D4, 4'hF, "R2");
        run_xfer(2'd0, 1'b0, 21'h000010, 32'h0, 4'h0, "R2");
    endtask

    task automatic t_byte32;
        run_xfer(2'd0, 1'b1, 21'h000010, 32'h00005500, 4'b0010, "R2");
        run_xfer(2'd0, 1'b0, 21'h000010, 32'h0, 4'h0, "R2");
        chk(rdata == 32'hA1B255D4, "R2", "byte merge", rdata, 32'hA1B255D4);
    endtask

    task automatic t_half16;
        logic [31:0] keep;
        keep = rdata;
        run_xfer(2'd1, 1'b1, 21'h100006, 32'h0000BEEF, 4'b0001, "R10");
        chk(rdata == keep, "R7", "read data kept over write", rdata, keep);
        run_xfer(2'd1, 1'b0, 21'h100006, 32'h0, 4'h0, "R3");
        chk(rdata[15:0] == 16'h00EF, "R3", "low byte only", rdata, 32'h000000EF);
        run_xfer(2'd1, 1'b1, 21'h00000A, 32'h00001234, 4'b0011, "R3");
        run_xfer(2'd1, 1'b0, 21'h00000A, 32'h0, 4'h0, "R3");
        chk(rdata == 32'h00001234, "R3", "bank0 halfword", rdata, 32'h00001234);
    endtask

    task automatic t_byte8;
        run_xfer(2'd2, 1'b1, 21'h180007, 32'h0000005A, 4'b0000, "R4");
        run_xfer(2'd2, 1'b0, 21'h180007, 32'h0, 4'h0, "R4");
        chk(rdata == 32'h0000005A, "R4", "bank3 byte", rdata, 32'h0000005A);
        run_xfer(2'd2, 1'b0, 21'h080004, 32'h0, 4'h0, "R4");
        chk(rdata == 32'h00000055, "R4", "bank1 byte from word write", rdata, 32'h00000055);
    endtask

    task automatic t_reserved;
        run_xfer(2'd3, 1'b1, 21'h000010, 32'hFFFFFFFF, 4'hF, "R9");
        run_xfer(2'd3, 1'b0, 21'h000010, 32'h0, 4'h0, "R9");
        chk(rdata == 32'h0, "R9", "reserved read zero", rdata, 32'h0);
        run_xfer(2'd0, 1'b0, 21'h000010, 32'h0, 4'h0, "R9");
        chk(rdata == 32'hA1B255D4, "R9", "memory untouched", rdata, 32'hA1B255D4);
    endtask

    // Done of a write and acceptance of a held read in the same cycle.
    task automatic t_back_to_back;
        bit bad_addr;
        int guard;
        bad_addr = 0; guard = 0;
        @(negedge clk);
        while (busy) @(negedge clk);
        cfg_mode = 2'd0; req_valid = 1'b1; req_write = 1'b1;
        req_addr = 21'h000024; req_wdata = 32'h0F1E2D3C; req_be = 4'hF;
        @(negedge clk);
        req_write = 1'b0; req_addr = 21'h000010; req_wdata = 32'hDEADBEEF;
        while (!done && guard < 64) begin
            guard++;
            if (mem_addr != 19'd9) bad_addr = 1;
            @(negedge clk);
        end
        chk(!bad_addr, "R8", "held request leaves write address", {13'h0, mem_addr}, 32'd9);
        chk(done && !busy && req_valid, "R8", "done cycle with request waiting",
            {29'h0, done, busy, req_valid}, 32'b101);
        for (int b = 0; b < 4; b++) shadow[b][9] = req_wdata_exp(b);
        @(negedge clk);
        chk(busy && !mem_oe_n, "R8", "held read accepted on done", {30'h0, busy, mem_oe_n}, 32'b10);
        req_valid = 1'b0;
        guard = 0;
        while (!done && guard < 64) begin guard++; @(negedge clk); end
        chk(rdata == 32'hA1B255D4, "R8", "held read data", rdata, 32'hA1B255D4);
        run_xfer(2'd0, 1'b0, 21'h000024, 32'h0, 4'h0, "R8");
        chk(rdata == 32'h0F1E2D3C, "R8", "write not disturbed", rdata, 32'h0F1E2D3C);
    endtask

    function automatic logic [7:0] req_wdata_exp(input int b);
        logic [31:0] w;
        w = 32'h0F1E2D3C;
        return w[b*8 +: 8];
    endfunction

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_pass, n_chk);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            n_chk++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        for (int b = 0; b < 4; b++)
            for (int w = 0; w < 16; w++) shadow[b][w] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word32();
        t_byte32();
        t_half16();
        t_byte8();
        t_reserved();
        t_back_to_back();
        finish_run();
    end
endmodule